// File: doc/BRIEF.md
# Key-Locked SDRAM Controller Configuration Registers

This block is the software-visible configuration space of an SDRAM controller. It holds a small array of 32-bit words behind a single-cycle bus slave port with a valid strobe, a write enable, a byte address, write data, registered read data and a registered error pulse. Word 0 is a protection word. Every other word accepts writes only while the protection word holds the 32-bit unlock key 0xFC600309. Word 1 is the controller configuration word. It carries the DRAM size code, the ECC, scramble and cache controls, and a hardware version field.

A synthesis-time revision parameter selects one of two register layouts. The choice sets which configuration bits are read-only, how the two-bit size code maps to a capacity, and the configuration value loaded at reset. The RAM capacity in megabytes arrives on an input and is sampled while reset is held. A capacity that the active revision cannot encode falls back to size code 0. Accesses that are not word-aligned, or that fall beyond the implemented words, read as zero, change nothing and raise the error pulse.

Top module: `memctl_cfg_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the protection word and all spare words clear to zero, `bus_err` and `bus_rdata` go to zero, and the configuration word loads its default. The revision 0 default is 0x00000040 OR the size code. The revision 1 default is 0x1000000C OR the size code.
- R2: The size code sits in configuration bits 1:0. Revision 0 maps 64/128/256/512 MB to codes 0/1/2/3. Revision 1 maps 128/256/512/1024 MB to codes 0/1/2/3. Any other `ram_mb` value gives code 0.
- R3: A write to byte address 0x000 always stores `bus_wdata` in the protection word, whether the block is locked or not.
- R4: While the protection word differs from 0xFC600309, a write to any implemented word other than word 0 leaves every word unchanged and raises `bus_err`.
- R5: An accepted configuration write (byte address 0x004) produces (old AND mask) OR (data AND NOT mask). The mask is 0xFFFFF84C for revision 0 and 0xF00FC04C for revision 1.
- R6: A read of an implemented word returns its current value on `bus_rdata` in the cycle after the access. In every cycle not following a read, `bus_rdata` is zero.
- R7: An access whose address has bits 1:0 not zero, or whose word index (address bits 11:2) is NUM_REGS or more, returns zero on a read, changes no word on a write, and raises `bus_err`.
- R8: `bus_err` is high for exactly the one cycle after an offending access and is low after every accepted access and every idle cycle.
- R9: Writing any value other than the key to the protection word locks the block again. Later writes to words other than word 0 are then dropped.
- R10: While unlocked, a write to a spare word (word 2 up to NUM_REGS-1) stores all 32 bits, and a read returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; `ram_mb` is sampled while it is high |
| ram_mb | input | MB_W | Installed RAM capacity in megabytes |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, zero when no read happened |
| bus_err | output | 1 | One-cycle pulse for a locked write or an out-of-range or misaligned access |

## Verification
The bound checker covers the cycle-level rules on every cycle:
- a protection write always lands;
- a locked write leaves the stored words as they were and raises the error;
- the read-only configuration bits never move after reset;
- out-of-range accesses return zero with an error;
- the error and read-data outputs stay quiet after idle cycles.

Only the bench scenarios can show the remaining behaviour. These are the reset defaults for each capacity, including the fallback for unsupported sizes, and the exact merged configuration values for each revision. They also include the relock sequence and full-width storage of spare words. The bench drives two instances, one per revision, with the same random and directed traffic.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

  // word indices whose position other logic depends on
  localparam int unsigned IDX_PROT = 0;
  localparam int unsigned IDX_CONF = 1;

  // capacity of size code 0 per revision, in MB
  function automatic int unsigned size_base_mb(input int unsigned rev);
    return (rev == 0) ? 64 : 128;
  endfunction

  // configuration bits that software cannot change
  function automatic logic [DATA_W-1:0] cfg_ro_mask(input int unsigned rev);
    logic [DATA_W-1:0] m;
    m = '0;
    if (rev == 0) begin
      m[31:11] = '1;
    end else begin
      m[31:28] = '1;            // hardware version
      m[19]    = 1'b1;          // cache init done
      m[18:14] = '1;
    end
    m[6]   = 1'b1;              // VGA compatibility
    m[3:2] = 2'b11;             // VGA aperture
    return m;
  endfunction

  // configuration value after reset
  function automatic logic [DATA_W-1:0] cfg_reset_value(input int unsigned rev,
                                                        input logic [1:0] code);
    logic [DATA_W-1:0] d;
    d      = '0;
    d[1:0] = code;
    if (rev == 0) begin
      d[6] = 1'b1;
    end else begin
      d[31:28] = 4'd1;
      d[3:2]   = 2'b11;
    end
    return d;
  endfunction

endpackage

// File: rtl/mcr_size_enc.sv
module mcr_size_enc #(
  parameter int unsigned REV  = 0,
  parameter int unsigned MB_W = 11
) (
  input  logic [MB_W-1:0] ram_mb,
  output logic [1:0]      size_code
);
  localparam int unsigned BASE_MB = mcr_pkg::size_base_mb(REV);
  localparam int unsigned N_CODES = 4;

  logic [N_CODES-1:0] hit;

  for (genvar i = 0; i < N_CODES; i++) begin : g_cmp
    localparam int unsigned CAP_MB = BASE_MB << i;
    assign hit[i] = (ram_mb == MB_W'(CAP_MB));
  end

  // unsupported capacity leaves code 0
  always_comb begin
    size_code = 2'd0;
    for (int i = 0; i < N_CODES; i++) begin
      if (hit[i]) size_code = 2'(i);
    end
  end
endmodule

// File: rtl/mcr_decode.sv
module mcr_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic              valid,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              unlocked,
  output logic [IDX_W-1:0]  idx,
  output logic              do_write,
  output logic              do_read,
  output logic              err
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              in_range;
  logic              is_prot;
  logic              wr_allowed;

  assign word       = addr[ADDR_W-1:2];
  assign aligned    = (addr[1:0] == 2'b00);
  assign in_range   = aligned && (32'(word) < NUM_REGS);
  assign idx        = word[IDX_W-1:0];
  assign is_prot    = (32'(word) == mcr_pkg::IDX_PROT);
  assign wr_allowed = is_prot || unlocked;

  assign do_write = valid && we && in_range && wr_allowed;
  assign do_read  = valid && !we && in_range;
  assign err      = valid && (!in_range || (we && !wr_allowed));
endmodule

// File: rtl/mcr_regfile.sv
module mcr_regfile #(
  parameter int unsigned REV      = 0,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [mcr_pkg::DATA_W-1:0] reset_cfg,
  input  logic                      do_write,
  input  logic                      do_read,
  input  logic [IDX_W-1:0]          idx,
  input  logic [mcr_pkg::DATA_W-1:0] wdata,
  output logic [mcr_pkg::DATA_W-1:0] rdata_q,
  output logic [mcr_pkg::DATA_W-1:0] prot_word,
  output logic [mcr_pkg::DATA_W-1:0] conf_word
);
  localparam int unsigned          DW      = mcr_pkg::DATA_W;
  localparam logic [DW-1:0]        RO_MASK = mcr_pkg::cfg_ro_mask(REV);
  localparam logic [IDX_W-1:0]     CONF_IX = IDX_W'(mcr_pkg::IDX_CONF);

  logic [DW-1:0] word_q [NUM_REGS];
  logic [DW-1:0] merged;

  assign merged = (word_q[mcr_pkg::IDX_CONF] & RO_MASK) | (wdata & ~RO_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) word_q[i] <= '0;
      word_q[mcr_pkg::IDX_CONF] <= reset_cfg;
      rdata_q <= '0;
    end else begin
      if (do_write) begin
        if (idx == CONF_IX) word_q[idx] <= merged;
        else                word_q[idx] <= wdata;
      end
      rdata_q <= do_read ? word_q[idx] : '0;
    end
  end

  assign prot_word = word_q[mcr_pkg::IDX_PROT];
  assign conf_word = word_q[mcr_pkg::IDX_CONF];
endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs #(
  parameter int unsigned REV      = 0,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned MB_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MB_W-1:0]   ram_mb,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err
);
  localparam int unsigned IDX_W = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1;

  if (REV > 1) begin : g_bad_rev
    $error("memctl_cfg_regs: REV must be 0 or 1");
  end
  if (NUM_REGS < 2 || NUM_REGS >= (1 << (ADDR_W - 2))) begin : g_bad_regs
    $error("memctl_cfg_regs: NUM_REGS out of range");
  end

  logic [1:0]       size_code;
  logic [31:0]      reset_cfg;
  logic [IDX_W-1:0] idx;
  logic             do_write;
  logic             do_read;
  logic             err_now;
  logic             unlocked;
  logic [31:0]      prot_word;
  logic [31:0]      conf_word;
  logic             err_q;

  mcr_size_enc #(.REV(REV), .MB_W(MB_W)) u_size (
    .ram_mb    (ram_mb),
    .size_code (size_code)
  );

  assign reset_cfg = mcr_pkg::cfg_reset_value(REV, size_code);
  assign unlocked  = (prot_word == mcr_pkg::UNLOCK_KEY);

  mcr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
    .valid    (bus_valid),
    .we       (bus_we),
    .addr     (bus_addr),
    .unlocked (unlocked),
    .idx      (idx),
    .do_write (do_write),
    .do_read  (do_read),
    .err      (err_now)
  );

  mcr_regfile #(.REV(REV), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reset_cfg (reset_cfg),
    .do_write  (do_write),
    .do_read   (do_read),
    .idx       (idx),
    .wdata     (bus_wdata),
    .rdata_q   (bus_rdata),
    .prot_word (prot_word),
    .conf_word (conf_word)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_now;
  end

  assign bus_err = err_q;
endmodule

// File: rtl/memctl_cfg_regs_chk.sv
module memctl_cfg_regs_chk #(
  parameter int unsigned REV      = 0,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic [31:0]       prot_word,
  input logic [31:0]       conf_word
);
  localparam logic [31:0] KEY = 32'hFC60_0309;
  localparam logic [31:0] RO  = (REV == 0) ? 32'hFFFF_F84C : 32'hF00F_C04C;

  logic inr;
  assign inr = (bus_addr[1:0] == 2'b00) && (32'(bus_addr >> 2) < NUM_REGS);

  assert_prot_write_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we && bus_addr == '0) |=> (prot_word == $past(bus_wdata)));

  assert_locked_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we && inr && bus_addr[ADDR_W-1:2] != '0 && prot_word != KEY)
    |=> (bus_err && $stable(conf_word) && $stable(prot_word)));

  assert_ro_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((conf_word & RO) == ($past(conf_word) & RO)));

  assert_read_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_we) |=> (bus_rdata == '0));

  assert_oor_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !inr) |=> (bus_err && bus_rdata == '0));

  assert_err_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !bus_err);
endmodule

bind memctl_cfg_regs memctl_cfg_regs_chk #(
  .REV(REV), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .prot_word (prot_word),
  .conf_word (conf_word)
);

// File: tb/memctl_cfg_regs_tb.sv
`timescale 1ns/1ps
module memctl_cfg_regs_tb;
  localparam logic [31:0] KEY = 32'hFC60_0309;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] ram_mb = 11'd64;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        err_a, err_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_word [2][4];

  always #2.5 clk = ~clk;

  memctl_cfg_regs #(.REV(0)) u_dut (
    .clk(clk), .rst(rst), .ram_mb(ram_mb), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .bus_err(err_a));

  memctl_cfg_regs #(.REV(1)) u_dut_b (
    .clk(clk), .rst(rst), .ram_mb(ram_mb), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .bus_err(err_b));

  function automatic logic [31:0] exp_ro(input int d);
    return (d == 0) ? 32'hFFFF_F84C : 32'hF00F_C04C;
  endfunction

  function automatic logic [1:0] exp_code(input int d, input int mb);
    if (d == 0)
      case (mb) 64: return 2'd0; 128: return 2'd1; 256: return 2'd2; 512: return 2'd3; default: return 2'd0; endcase
    else
      case (mb) 128: return 2'd0; 256: return 2'd1; 512: return 2'd2; 1024: return 2'd3; default: return 2'd0; endcase
  endfunction

  function automatic logic [31:0] exp_default(input int d, input int mb);
    return ((d == 0) ? 32'h0000_0040 : 32'h1000_000C) | {30'd0, exp_code(d, mb)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int mb);
    @(negedge clk);
    rst = 1'b1; ram_mb = 11'(mb); bus_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 4; i++) m_word[d][i] = '0;
      m_word[d][1] = exp_default(d, mb);
    end
    chk(err_a == 1'b0 && err_b == 1'b0, "R1 err after reset", {30'd0, err_a, err_b}, 32'd0);
    chk(rdata_a == '0 && rdata_b == '0, "R1 rdata after reset", rdata_a | rdata_b, 32'd0);
  endtask

  task automatic access(input bit we, input logic [11:0] addr, input logic [31:0] wd, input string tag_in);
    bit          inr;
    int          w;
    bit          locked [2];
    logic [31:0] e_rd [2];
    bit          e_err [2];
    string       tag;
    w   = int'(addr >> 2);
    inr = (addr[1:0] == 2'b00) && (w < 4);
    for (int d = 0; d < 2; d++) begin
      locked[d] = (m_word[d][0] != KEY);
      e_err[d]  = !inr || (we && w != 0 && locked[d]);
      e_rd[d]   = (!we && inr) ? m_word[d][w] : 32'd0;
    end
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    for (int d = 0; d < 2; d++) begin
      if (tag_in.len() != 0)            tag = tag_in;
      else if (!inr)                    tag = "R7";
      else if (we && w != 0 && locked[d]) tag = "R4";
      else if (w == 0)                  tag = "R3";
      else if (w == 1)                  tag = we ? "R5" : "R6";
      else                              tag = "R10";
      tag = $sformatf("%s rev%0d addr=%03h we=%0d", tag, d, addr, we);
      chk(((d == 0) ? rdata_a : rdata_b) == e_rd[d], {tag, " rdata"},
          (d == 0) ? rdata_a : rdata_b, e_rd[d]);
      chk(((d == 0) ? err_a : err_b) == e_err[d], {tag, " err R8"},
          {31'd0, (d == 0) ? err_a : err_b}, {31'd0, e_err[d]});
      if (we && inr && (w == 0 || !locked[d])) begin
        if (w == 1) m_word[d][1] = (m_word[d][1] & exp_ro(d)) | (wd & ~exp_ro(d));
        else        m_word[d][w] = wd;
      end
    end
  endtask

  initial begin
    int sizes [7] = '{64, 128, 256, 512, 1024, 100, 0};
    int seed;
    seed = $urandom(32'h00C0_FFEE);
    foreach (sizes[k]) begin
      do_reset(sizes[k]);
      access(0, 12'h000, '0, "R1");
      access(0, 12'h004, '0, "R2");
      access(0, 12'h008, '0, "R1");
      access(1, 12'h004, 32'hFFFF_FFFF, "");   // locked drop
      access(0, 12'h004, '0, "R4");
      access(1, 12'h008, 32'h1234_5678, "");
      access(0, 12'h008, '0, "R4");
      access(1, 12'h000, KEY, "");
      access(0, 12'h000, '0, "R3");
      access(1, 12'h004, 32'hFFFF_FFFF, "");
      access(0, 12'h004, '0, "R5");
      access(1, 12'h004, 32'h0000_0000, "");
      access(0, 12'h004, '0, "R5");
      access(1, 12'h00C, 32'hA5A5_5A5A, "");
      access(0, 12'h00C, '0, "R10");
      access(0, 12'h010, '0, "");
      access(0, 12'hFFC, '0, "");
      access(1, 12'h010, 32'hDEAD_BEEF, "");
      access(0, 12'h005, '0, "");
      access(1, 12'h006, 32'h0, "");
      access(1, 12'h000, 32'h0000_1234, "R9");
      access(1, 12'h004, 32'h0000_0FFF, "R9");
      access(0, 12'h004, '0, "R9");
    end
    do_reset(256);
    for (int n = 0; n < 500; n++) begin
      logic [11:0] a;
      logic [31:0] v;
      bit          we;
      case ($urandom % 8)
        0: a = 12'h000; 1, 2: a = 12'h004; 3: a = 12'h008; 4: a = 12'h00C;
        5: a = 12'h010 + 12'($urandom % 64) * 4; 6: a = 12'($urandom);
        default: a = 12'h004;
      endcase
      we = $urandom % 2;
      v  = $urandom;
      if (a == 12'h000 && we && ($urandom % 4 != 0)) v = KEY;
      access(we, a, v, "");
    end
    for (int i = 0; i < 4; i++) access(0, 12'(i * 4), '0, "R6");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule